// File: doc/BRIEF.md
# Real-Time Clock Indexed Register Port

This block is the register side of a real-time clock. Software reaches it through two byte ports. A write to the index port selects one of fourteen locations. A read or write on the data port then reaches the selected location. Indices 0 to 9 are plain time and date storage. Indices 0xA to 0xD are four status registers. The block does not advance time: the stored bytes change only through data-port writes or through the load inputs.

The load inputs place an initial date and time into the storage bytes in one cycle. The month and the day of week are shifted to start at one. The year is stored either as a raw count or reduced to a two-digit BCD value, chosen per load. Status register A must carry the fixed time-base and rate selection, and each read of it flips its update-in-progress bit. Status register B must keep binary, 24-hour operation. Its periodic-enable bit gates an interrupt that fires once every `PERIOD_TICKS` strobes of an external tick input. An index value, or a write to a status register, that the block does not support raises a one-cycle error pulse and changes nothing.

Top module: `rtc_regport`

## Requirements
- R1: An index write with a value of 0x00 to 0x0D selects that location. A larger value leaves the selected location unchanged and pulses `err` high for one cycle. Reset selects index 0.
- R2: Indices 0 to 9 are byte storage. A data write stores the byte, and a later data read of the same index returns it.
- R3: Status register A (index 0xA) resets to 0x26. Each data read of it first flips bit 7 (update in progress) in the register and then returns the new value, so the first two reads after reset return 0xA6 and 0x26.
- R4: A data write to register A with the value 0x26 stores it. A write with any other value leaves register A unchanged and pulses `err`.
- R5: Status register B (index 0xB) resets to 0x46. A write of value v is stored only if (v & 0xB7) == 0x06, that is, bits other than 6 (periodic enable) and 3 (square-wave enable) are exactly binary format (bit 2) plus 24-hour mode (bit 1). Any other value leaves B unchanged and pulses `err`.
- R6: Registers C and D (indices 0xC and 0xD) read as 0x00. Writes to them pulse `err` and change nothing.
- R7: While bit 6 of B is set, `irq` is a one-cycle pulse on every `PERIOD_TICKS`-th cycle that has `tick` high. While bit 6 is clear, `irq` stays low and the tick count is held at zero, so after the bit is set again the first pulse comes after exactly `PERIOD_TICKS` ticks.
- R8: A cycle with `load` high writes seconds to index 0, minutes to index 2, hours to index 4, day of week plus one to index 6 (Sunday, input 0, is stored as 1), day of month to index 7, month plus one to index 8 (inputs 0 to 11 are stored as 1 to 12), and the year to index 9.
- R9: With `ld_bcd` high, the stored year is the input year modulo 100, with the tens digit in bits 7:4 and the ones digit in bits 3:0. With `ld_bcd` low, the input year is stored unchanged.
- R10: Read data appears on `data_dout` after the clock edge that samples `data_rd`, and it holds until the next read. `err` is high only in the cycle after the edge that sampled the rejected write. A data write issued in the same cycle as a data read takes priority, and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Index write strobe |
| idx_din | input | 8 | Index value |
| data_wr | input | 1 | Data write strobe |
| data_rd | input | 1 | Data read strobe |
| data_din | input | 8 | Data write byte |
| data_dout | output | 8 | Registered read byte |
| err | output | 1 | One-cycle pulse on a rejected index or data write |
| tick | input | 1 | Periodic time-base strobe |
| irq | output | 1 | Periodic interrupt pulse |
| load | input | 1 | Load the initial date and time |
| ld_bcd | input | 1 | Store the year as two-digit BCD |
| ld_year | input | 8 | Years since the epoch base |
| ld_mon | input | 4 | Month, 0 to 11 |
| ld_mday | input | 5 | Day of month |
| ld_hour | input | 5 | Hour, 0 to 23 |
| ld_min | input | 6 | Minute |
| ld_sec | input | 6 | Second |
| ld_wday | input | 3 | Day of week, 0 = Sunday |

## Verification
Every result is due one clock edge after its stimulus. This covers read data, the error pulse, the new index, stored bytes and the effect of a load. The bench therefore drives each strobe for exactly one cycle from the falling edge and samples at the next falling edge, after the single register has updated. The interrupt is due `PERIOD_TICKS` tick-carrying edges after the enabling write. The bench counts falling edges from that write until the pulse appears, and it measures later intervals the same way, at full and at half tick rate.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

    localparam int IDX_W      = 4;
    localparam int DATA_BYTES = 10;

    localparam logic [IDX_W-1:0] IDX_A   = 4'hA;
    localparam logic [IDX_W-1:0] IDX_B   = 4'hB;
    localparam logic [IDX_W-1:0] IDX_C   = 4'hC;
    localparam logic [IDX_W-1:0] IDX_MAX = 4'hD;

    localparam logic [7:0] A_INIT  = 8'h26;
    localparam logic [7:0] A_UIP   = 8'h80;
    localparam logic [7:0] B_PIE   = 8'h40;
    localparam logic [7:0] B_SQW   = 8'h08;
    localparam logic [7:0] B_FIXED = 8'h06;
    localparam logic [7:0] B_INIT  = 8'h46;

    localparam int SLOT_SEC  = 0;
    localparam int SLOT_MIN  = 2;
    localparam int SLOT_HOUR = 4;
    localparam int SLOT_WDAY = 6;
    localparam int SLOT_MDAY = 7;
    localparam int SLOT_MON  = 8;
    localparam int SLOT_YEAR = 9;

    typedef struct packed {
        logic [7:0] year;
        logic [3:0] mon0;
        logic [4:0] mday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
        logic [2:0] wday0;
    } rtc_load_t;

    function automatic logic [7:0] year_code(input logic [7:0] y, input logic bcd);
        logic [7:0] r;
        logic [3:0] tens;
        logic [3:0] ones;
        r    = y % 8'd100;
        tens = 4'(r / 8'd10);
        ones = 4'(r % 8'd10);
        return bcd ? {tens, ones} : y;
    endfunction

    function automatic logic b_value_ok(input logic [7:0] v);
        return (v & ~(B_PIE | B_SQW)) == B_FIXED;
    endfunction

endpackage

// File: rtl/rtc_index.sv
module rtc_index
    import rtc_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [7:0]       din,
    output logic [IDX_W-1:0] idx,
    output logic             err
);
    logic in_range;
    assign in_range = din <= {4'h0, IDX_MAX};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            err <= 1'b0;
        end else begin
            err <= wr && !in_range;
            if (wr && in_range)
                idx <= din[IDX_W-1:0];
        end
    end

    // R1
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && din > 8'h0D) |=> ($stable(idx) && err));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_MAX);

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
    parameter int PERIOD_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic irq
);
    localparam int CNT_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (tick) begin
                if (cnt == LAST) begin
                    cnt <= '0;
                    irq <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    initial begin
        if (PERIOD_TICKS < 2) $error("PERIOD_TICKS must be at least 2");
    end

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq);

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    input  logic             rd,
    input  logic [7:0]       din,
    output logic [7:0]       dout,
    output logic             err,
    input  logic             load,
    input  logic             ld_bcd,
    input  rtc_load_t        ld,
    output logic             pie
);
    localparam logic [IDX_W-1:0] DATA_LIM = IDX_W'(DATA_BYTES);

    logic [7:0] mem [DATA_BYTES];
    logic [7:0] stat_a;
    logic [7:0] stat_b;
    logic       is_data;
    logic       rd_only;
    logic       bad_wr;
    logic [7:0] rd_val;

    assign is_data = idx < DATA_LIM;
    assign rd_only = rd && !wr;
    assign pie     = (stat_b & B_PIE) != 8'h00;

    always_comb begin
        bad_wr = 1'b0;
        if (wr && !is_data) begin
            unique case (idx)
                IDX_A:   bad_wr = din != A_INIT;
                IDX_B:   bad_wr = !b_value_ok(din);
                default: bad_wr = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (is_data)         rd_val = mem[idx];
        else if (idx == IDX_A) rd_val = stat_a ^ A_UIP;
        else if (idx == IDX_B) rd_val = stat_b;
        else                 rd_val = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DATA_BYTES; i++) mem[i] <= 8'h00;
            stat_a <= A_INIT;
            stat_b <= B_INIT;
            dout   <= 8'h00;
            err    <= 1'b0;
        end else begin
            err <= bad_wr;
            if (load) begin
                mem[SLOT_SEC]  <= {2'b00, ld.sec};
                mem[SLOT_MIN]  <= {2'b00, ld.min};
                mem[SLOT_HOUR] <= {3'b000, ld.hour};
                mem[SLOT_WDAY] <= {5'b00000, ld.wday0} + 8'd1;
                mem[SLOT_MDAY] <= {3'b000, ld.mday};
                mem[SLOT_MON]  <= {4'h0, ld.mon0} + 8'd1;
                mem[SLOT_YEAR] <= year_code(ld.year, ld_bcd);
            end else if (wr && is_data) begin
                mem[idx] <= din;
            end
            if (wr && !bad_wr && idx == IDX_A) stat_a <= din;
            if (wr && !bad_wr && idx == IDX_B) stat_b <= din;
            if (rd_only) begin
                dout <= rd_val;
                if (idx == IDX_A) stat_a <= stat_a ^ A_UIP;
            end
        end
    end

    // R4
    a_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == IDX_A && din != A_INIT) |=> ($stable(stat_a) && err));

    // R5
    b_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == IDX_B && (din & 8'hB7) != 8'h06) |=> ($stable(stat_b) && err));

    // R6
    cd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && idx >= IDX_C) |=> dout == 8'h00);

    // R3
    a_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && idx == IDX_A) |=> (stat_a == ($past(stat_a) ^ A_UIP) && dout == stat_a));

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_port_pkg::*;
#(
    parameter int PERIOD_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] idx_din,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] data_din,
    output logic [7:0] data_dout,
    output logic       err,
    input  logic       tick,
    output logic       irq,
    input  logic       load,
    input  logic       ld_bcd,
    input  logic [7:0] ld_year,
    input  logic [3:0] ld_mon,
    input  logic [4:0] ld_mday,
    input  logic [4:0] ld_hour,
    input  logic [5:0] ld_min,
    input  logic [5:0] ld_sec,
    input  logic [2:0] ld_wday
);
    logic [IDX_W-1:0] idx;
    logic             idx_err;
    logic             st_err;
    logic             pie;
    rtc_load_t        ld;

    always_comb begin
        ld.year  = ld_year;
        ld.mon0  = ld_mon;
        ld.mday  = ld_mday;
        ld.hour  = ld_hour;
        ld.min   = ld_min;
        ld.sec   = ld_sec;
        ld.wday0 = ld_wday;
    end

    rtc_index u_index (
        .clk (clk),
        .rst (rst),
        .wr  (idx_wr),
        .din (idx_din),
        .idx (idx),
        .err (idx_err)
    );

    rtc_store u_store (
        .clk    (clk),
        .rst    (rst),
        .idx    (idx),
        .wr     (data_wr),
        .rd     (data_rd),
        .din    (data_din),
        .dout   (data_dout),
        .err    (st_err),
        .load   (load),
        .ld_bcd (ld_bcd),
        .ld     (ld),
        .pie    (pie)
    );

    rtc_periodic #(.PERIOD_TICKS(PERIOD_TICKS)) u_periodic (
        .clk  (clk),
        .rst  (rst),
        .en   (pie),
        .tick (tick),
        .irq  (irq)
    );

    assign err = idx_err | st_err;

endmodule

// File: tb/tb_rtc_regport.sv
module tb_rtc_regport;
    localparam int PER = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idx_wr = 0, data_wr = 0, data_rd = 0, tick = 0, load = 0, ld_bcd = 0;
    logic [7:0] idx_din = 0, data_din = 0, ld_year = 0;
    logic [3:0] ld_mon = 0;
    logic [4:0] ld_mday = 0, ld_hour = 0;
    logic [5:0] ld_min = 0, ld_sec = 0;
    logic [2:0] ld_wday = 0;
    logic [7:0] data_dout;
    logic       err, irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rtc_regport #(.PERIOD_TICKS(PER)) dut (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .idx_din(idx_din),
        .data_wr(data_wr), .data_rd(data_rd), .data_din(data_din),
        .data_dout(data_dout), .err(err), .tick(tick), .irq(irq),
        .load(load), .ld_bcd(ld_bcd), .ld_year(ld_year), .ld_mon(ld_mon),
        .ld_mday(ld_mday), .ld_hour(ld_hour), .ld_min(ld_min),
        .ld_sec(ld_sec), .ld_wday(ld_wday)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic put_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1; idx_din = v;
        @(negedge clk); idx_wr = 0;
    endtask

    task automatic put_data(input logic [7:0] v);
        @(negedge clk); data_wr = 1; data_din = v;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic get_data(output logic [7:0] v);
        @(negedge clk); data_rd = 1;
        @(negedge clk); data_rd = 0; v = data_dout;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got 00 expected 01");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] a_model;
        int n;
        repeat (3) @(negedge clk);
        check("R10 reset dout", data_dout, 8'h00);
        check("R1 reset err", {7'b0, err}, 8'h00);
        rst = 0;

        // R3 reset value and toggling (index 0 after reset, select A)
        put_idx(8'h0A);
        check("R1 in-range err", {7'b0, err}, 8'h00);
        get_data(v); check("R3 first read A", v, 8'hA6);
        get_data(v); check("R3 second read A", v, 8'h26);
        a_model = 8'h26;

        // R5 reset value of B
        put_idx(8'h0B);
        get_data(v); check("R5 reset B", v, 8'h46);

        // R2 storage sweep, two patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 10; i++) begin
                put_idx(8'(i)); put_data(8'((i * 37 + 11) ^ (p * 255)));
                check("R2 write err", {7'b0, err}, 8'h00);
            end
            for (int i = 0; i < 10; i++) begin
                put_idx(8'(i)); get_data(v);
                check("R2 readback", v, 8'((i * 37 + 11) ^ (p * 255)));
            end
        end

        // R1 index sweep
        put_idx(8'd3); put_data(8'h5C);
        for (int a = 0; a < 256; a++) begin
            put_idx(8'(a));
            if (a > 13) begin
                check("R1 bad index err", {7'b0, err}, 8'h01);
                get_data(v); check("R1 index held", v, 8'h5C);
            end else begin
                check("R1 good index err", {7'b0, err}, 8'h00);
                put_idx(8'd3);
            end
        end

        // R4 register A write sweep
        put_idx(8'h0A);
        for (int d = 0; d < 256; d++) begin
            put_data(8'(d));
            check("R4 A write err", {7'b0, err}, (d == 8'h26) ? 8'h01 ^ 8'h01 : 8'h01);
            if (d == 8'h26) a_model = 8'h26;
            if (d % 16 == 5 || d == 8'h26) begin
                get_data(v); a_model = a_model ^ 8'h80;
                check("R4 A content", v, a_model);
            end
        end

        // R10 write beats read in same cycle
        @(negedge clk); data_wr = 1; data_rd = 1; data_din = 8'h26;
        @(negedge clk); data_wr = 0; data_rd = 0;
        check("R10 read ignored on write", data_dout, a_model);
        a_model = 8'h26;

        // R5 register B write sweep
        put_idx(8'h0B);
        begin
            logic [7:0] b_model;
            b_model = 8'h46;
            for (int d = 0; d < 256; d++) begin
                put_data(8'(d));
                if ((d & 8'hB7) == 8'h06) begin
                    b_model = 8'(d);
                    check("R5 B accept err", {7'b0, err}, 8'h00);
                end else begin
                    check("R5 B reject err", {7'b0, err}, 8'h01);
                end
                if (d % 8 == 6 || d % 32 == 7) begin
                    get_data(v); check("R5 B content", v, b_model);
                end
            end
        end

        // R6 C and D
        for (int r = 12; r < 14; r++) begin
            put_idx(8'(r));
            put_data(8'hFF); check("R6 C/D write err", {7'b0, err}, 8'h01);
            get_data(v); check("R6 C/D read", v, 8'h00);
        end

        // R7 periodic interrupt
        put_idx(8'h0B); put_data(8'h06);
        tick = 1; n = 0;
        repeat (20) begin @(negedge clk); if (irq) n++; end
        check("R7 disabled no irq", 8'(n), 8'h00);
        tick = 0;
        put_data(8'h46);
        tick = 1; n = 0;
        for (int k = 0; k < 4; k++) begin
            n = 0;
            do begin @(negedge clk); n++; end while (!irq && n < 50);
            check("R7 full-rate interval", 8'(n), 8'(PER));
        end
        @(negedge clk); check("R7 pulse one cycle", {7'b0, irq}, 8'h00);
        tick = 0; put_data(8'h06); put_data(8'h4E);
        for (int k = 0; k < 3; k++) begin
            n = 0;
            do begin @(negedge clk); n++; tick = (n % 2 == 1); end while (!irq && n < 50);
            check("R7 half-rate interval", 8'(n), 8'(2 * PER));
        end
        tick = 0;

        // R8 / R9 load
        for (int c = 0; c < 4; c++) begin
            logic [7:0] yr;
            logic [7:0] exp_y;
            yr = (c == 0) ? 8'd123 : (c == 1) ? 8'd99 : (c == 2) ? 8'd100 : 8'd205;
            @(negedge clk);
            load = 1; ld_bcd = c[0] | c[1]; ld_year = yr;
            ld_mon = 4'(11 - c); ld_mday = 5'(c + 28); ld_hour = 5'(23 - c);
            ld_min = 6'(59 - c); ld_sec = 6'(c * 7); ld_wday = 3'(c);
            @(negedge clk); load = 0;
            if (c[0] | c[1]) exp_y = 8'(((yr % 100) / 10) * 16 + (yr % 10));
            else             exp_y = yr;
            put_idx(8'd9); get_data(v); check("R9 year", v, exp_y);
            put_idx(8'd8); get_data(v); check("R8 month", v, 8'(12 - c));
            put_idx(8'd6); get_data(v); check("R8 weekday", v, 8'(c + 1));
            put_idx(8'd7); get_data(v); check("R8 mday", v, 8'(c + 28));
            put_idx(8'd4); get_data(v); check("R8 hour", v, 8'(23 - c));
            put_idx(8'd2); get_data(v); check("R8 minute", v, 8'(59 - c));
            put_idx(8'd0); get_data(v); check("R8 second", v, 8'(c * 7));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule